// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible control and status store of a multi-channel memory-access layer that serves network transmit and receive channels. A processor reaches it over a simple register bus with a write strobe and combinational read data. It keeps a global configuration word whose top bit triggers a self-clearing soft reset, an error status word, a five-bit interrupt enable, and one active-channel mask per direction. Each mask is changed through a separate set address and a separate clear address. It also keeps write-one-to-clear end-of-buffer and descriptor-error status words for each direction.

Per-channel storage holds a 32-bit descriptor table pointer for every transmit and every receive channel, and a narrow buffer-size value for every receive channel. The number of channels in each direction is fixed at build time, to at most 32. Side inputs let the neighbouring engine, or a testbench, raise status bits. Five interrupt outputs report each status class that is non-zero and enabled. Fetching descriptors and moving data happen elsewhere.

Top module: `dmac_ctl_regfile`

## Requirements
- R1: After hardware reset the configuration word reads 0x0007C000, and every other register reads zero: status, enable, active masks, pointers and sizes. All interrupt outputs are low.
- R2: A write to configuration (0x180) stores the written value ANDed with 0x00FFC087, so bit 31 never reads back as one.
- R3: A configuration write with bit 31 set first clears error status, interrupt enable, both active masks and all four end-of-buffer and descriptor-error words, ignoring side-input events in that cycle, and then stores the masked value. Descriptor pointers and buffer sizes keep their contents.
- R4: Error status (0x181), transmit end-of-buffer (0x186), transmit descriptor-error (0x187), receive end-of-buffer (0x192) and receive descriptor-error (0x193) are write-one-to-clear. A side-input event arriving in the same cycle as a clear of the same bit leaves that bit set.
- R5: A one on side-input bit n of a per-channel event vector sets status bit 31-n of the matching status word. A one on error-event bit k sets error-status bit k.
- R6: Interrupt enable (0x182) keeps only bits 4:0. The bits are: bit 0 error, bit 1 transmit end-of-buffer, bit 2 receive end-of-buffer, bit 3 transmit descriptor-error, bit 4 receive descriptor-error.
- R7: A one written to transmit-set (0x184) or receive-set (0x190) sets that active bit, and a one written to transmit-clear (0x185) or receive-clear (0x191) clears it. Only the top TX_CH or RX_CH bits take effect (31:28 and 31:30 by default). Both the set and the clear address read back the current mask.
- R8: Transmit pointers sit at 0x1A0+n and receive pointers at 0x1C0+n, each 32 bits wide. Receive buffer sizes sit at 0x1E0+n and keep the low 8 bits.
- R9: Reads of an unmapped address return zero, and writes to one change nothing. This includes 0x183 and pointer or size slots at or beyond the channel count.
- R10: Each interrupt output is high exactly when its status word is non-zero and its R6 enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Register address |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_err | input | 32 | Error events, bit k sets error-status bit k |
| ev_txeob | input | TX_CH | Transmit end-of-buffer events per channel |
| ev_txde | input | TX_CH | Transmit descriptor-error events per channel |
| ev_rxeob | input | RX_CH | Receive end-of-buffer events per channel |
| ev_rxde | input | RX_CH | Receive descriptor-error events per channel |
| irq_err | output | 1 | Error interrupt |
| irq_txeob | output | 1 | Transmit end-of-buffer interrupt |
| irq_rxeob | output | 1 | Receive end-of-buffer interrupt |
| irq_txde | output | 1 | Transmit descriptor-error interrupt |
| irq_rxde | output | 1 | Receive descriptor-error interrupt |

## Verification
Configuration and enable writes use all-ones data and a mixed pattern, which separates the right keep-mask from a shifted or missing one. Active masks are set, partly cleared and set again with data that has ones both inside and outside the channel field, so a set/clear swap or a wrong field width shows up. Sparse event vectors with gaps (channels 0 and 2, receive channel 1) expose a reversed bit mapping, and a clear that collides with a new event tells event priority apart from clear priority. The soft-reset write comes after pointers, sizes and status are all non-zero, so it shows which state survives and which is wiped.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;

    // Register offsets; the pointer/size windows are 32-slot aligned blocks.
    localparam int ADR_CFG    = 'h180;
    localparam int ADR_ESR    = 'h181;
    localparam int ADR_IEN    = 'h182;
    localparam int ADR_TXSET  = 'h184;
    localparam int ADR_TXCLR  = 'h185;
    localparam int ADR_TXEOB  = 'h186;
    localparam int ADR_TXDE   = 'h187;
    localparam int ADR_RXSET  = 'h190;
    localparam int ADR_RXCLR  = 'h191;
    localparam int ADR_RXEOB  = 'h192;
    localparam int ADR_RXDE   = 'h193;
    localparam int ADR_TXPTR  = 'h1A0;
    localparam int ADR_RXPTR  = 'h1C0;
    localparam int ADR_BSZ    = 'h1E0;
    localparam int WIN_OFS_W  = 5;

    localparam logic [31:0] CFG_KEEP  = 32'h00FFC087;
    localparam logic [31:0] CFG_INIT  = 32'h0007C000;
    localparam int          SRST_BIT  = 31;
    localparam int          IEN_W     = 5;

    // Interrupt enable bit positions
    localparam int IE_ERR   = 0;
    localparam int IE_TXEOB = 1;
    localparam int IE_RXEOB = 2;
    localparam int IE_TXDE  = 3;
    localparam int IE_RXDE  = 4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_ESR,
        SEL_IEN,
        SEL_TXSET,
        SEL_TXCLR,
        SEL_TXEOB,
        SEL_TXDE,
        SEL_RXSET,
        SEL_RXCLR,
        SEL_RXEOB,
        SEL_RXDE
    } core_sel_e;

    typedef struct packed {
        logic [31:0] cfg;
        logic [31:0] esr;
        logic [31:0] ien;
        logic [31:0] txact;
        logic [31:0] rxact;
        logic [31:0] txeob;
        logic [31:0] txde;
        logic [31:0] rxeob;
        logic [31:0] rxde;
    } core_regs_t;

    localparam core_regs_t CORE_INIT = '{
        cfg:   CFG_INIT,
        esr:   32'h0,
        ien:   32'h0,
        txact: 32'h0,
        rxact: 32'h0,
        txeob: 32'h0,
        txde:  32'h0,
        rxeob: 32'h0,
        rxde:  32'h0
    };

endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
    import dmac_reg_pkg::*;
#(
    parameter int AW    = 10,
    parameter int TX_CH = 4,
    parameter int RX_CH = 2,
    parameter int TX_IW = 2,
    parameter int RX_IW = 1
) (
    input  logic [AW-1:0]    addr,
    output core_sel_e        sel,
    output logic             txp_hit,
    output logic [TX_IW-1:0] txp_idx,
    output logic             rxp_hit,
    output logic [RX_IW-1:0] rxp_idx,
    output logic             bsz_hit,
    output logic [RX_IW-1:0] bsz_idx
);

    localparam int BLK_W = AW - WIN_OFS_W;

    logic [WIN_OFS_W-1:0] ofs;
    logic [BLK_W-1:0]     blk;

    always_comb begin
        ofs = addr[WIN_OFS_W-1:0];
        blk = addr[AW-1:WIN_OFS_W];

        // Windowed per-channel slots: block match plus slot below the count
        txp_hit = (blk == BLK_W'(ADR_TXPTR >> WIN_OFS_W)) && (32'(ofs) < TX_CH);
        rxp_hit = (blk == BLK_W'(ADR_RXPTR >> WIN_OFS_W)) && (32'(ofs) < RX_CH);
        bsz_hit = (blk == BLK_W'(ADR_BSZ   >> WIN_OFS_W)) && (32'(ofs) < RX_CH);
        txp_idx = ofs[TX_IW-1:0];
        rxp_idx = ofs[RX_IW-1:0];
        bsz_idx = ofs[RX_IW-1:0];

        case (addr)
            AW'(ADR_CFG):   sel = SEL_CFG;
            AW'(ADR_ESR):   sel = SEL_ESR;
            AW'(ADR_IEN):   sel = SEL_IEN;
            AW'(ADR_TXSET): sel = SEL_TXSET;
            AW'(ADR_TXCLR): sel = SEL_TXCLR;
            AW'(ADR_TXEOB): sel = SEL_TXEOB;
            AW'(ADR_TXDE):  sel = SEL_TXDE;
            AW'(ADR_RXSET): sel = SEL_RXSET;
            AW'(ADR_RXCLR): sel = SEL_RXCLR;
            AW'(ADR_RXEOB): sel = SEL_RXEOB;
            AW'(ADR_RXDE):  sel = SEL_RXDE;
            default:        sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/dmac_slot_bank.sv
module dmac_slot_bank #(
    parameter int N  = 4,
    parameter int W  = 32,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data
);

    // Slots are cleared only by hardware reset; soft reset leaves them alone.
    logic [W-1:0] slot_d [N];
    logic [W-1:0] slot_q [N];

    always_comb begin
        for (int n = 0; n < N; n++) begin
            slot_d[n] = slot_q[n];
        end
        if (wr_en) begin
            slot_d[idx] = wr_data;
        end
        rd_data = slot_q[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N; n++) begin
                slot_q[n] <= '0;
            end
        end else begin
            for (int n = 0; n < N; n++) begin
                slot_q[n] <= slot_d[n];
            end
        end
    end

endmodule

// File: rtl/dmac_irq_gen.sv
module dmac_irq_gen
    import dmac_reg_pkg::*;
(
    input  logic [31:0]      esr,
    input  logic [31:0]      txeob,
    input  logic [31:0]      rxeob,
    input  logic [31:0]      txde,
    input  logic [31:0]      rxde,
    input  logic [IEN_W-1:0] ien,
    output logic             irq_err,
    output logic             irq_txeob,
    output logic             irq_rxeob,
    output logic             irq_txde,
    output logic             irq_rxde
);

    always_comb begin
        irq_err   = (|esr)   & ien[IE_ERR];
        irq_txeob = (|txeob) & ien[IE_TXEOB];
        irq_rxeob = (|rxeob) & ien[IE_RXEOB];
        irq_txde  = (|txde)  & ien[IE_TXDE];
        irq_rxde  = (|rxde)  & ien[IE_RXDE];
    end

endmodule

// File: rtl/dmac_ctl_regfile.sv
module dmac_ctl_regfile
    import dmac_reg_pkg::*;
#(
    parameter int TX_CH = 4,
    parameter int RX_CH = 2,
    parameter int AW    = 10,
    parameter int BSZ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [31:0]      ev_err,
    input  logic [TX_CH-1:0] ev_txeob,
    input  logic [TX_CH-1:0] ev_txde,
    input  logic [RX_CH-1:0] ev_rxeob,
    input  logic [RX_CH-1:0] ev_rxde,
    output logic             irq_err,
    output logic             irq_txeob,
    output logic             irq_rxeob,
    output logic             irq_txde,
    output logic             irq_rxde
);

    localparam int          TX_IW   = (TX_CH > 1) ? $clog2(TX_CH) : 1;
    localparam int          RX_IW   = (RX_CH > 1) ? $clog2(RX_CH) : 1;
    // Channel n owns bit 31-n, so the live field is the top CH bits.
    localparam logic [31:0] TX_MASK = ~(32'hFFFF_FFFF >> TX_CH);
    localparam logic [31:0] RX_MASK = ~(32'hFFFF_FFFF >> RX_CH);
    localparam logic [31:0] IEN_MASK = 32'((1 << IEN_W) - 1);

    core_sel_e        sel;
    logic             txp_hit, rxp_hit, bsz_hit;
    logic [TX_IW-1:0] txp_idx;
    logic [RX_IW-1:0] rxp_idx, bsz_idx;
    logic [31:0]      txp_rd, rxp_rd;
    logic [BSZ_W-1:0] bsz_rd;

    core_regs_t core_d, core_q;
    logic       soft_rst;
    logic [31:0] txeob_ev_w, txde_ev_w, rxeob_ev_w, rxde_ev_w;

    dmac_addr_dec #(
        .AW(AW), .TX_CH(TX_CH), .RX_CH(RX_CH), .TX_IW(TX_IW), .RX_IW(RX_IW)
    ) u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .txp_hit (txp_hit),
        .txp_idx (txp_idx),
        .rxp_hit (rxp_hit),
        .rxp_idx (rxp_idx),
        .bsz_hit (bsz_hit),
        .bsz_idx (bsz_idx)
    );

    dmac_slot_bank #(.N(TX_CH), .W(32), .IW(TX_IW)) u_txptr (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & txp_hit),
        .idx(txp_idx), .wr_data(bus_wdata), .rd_data(txp_rd)
    );

    dmac_slot_bank #(.N(RX_CH), .W(32), .IW(RX_IW)) u_rxptr (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & rxp_hit),
        .idx(rxp_idx), .wr_data(bus_wdata), .rd_data(rxp_rd)
    );

    dmac_slot_bank #(.N(RX_CH), .W(BSZ_W), .IW(RX_IW)) u_bsz (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr & bsz_hit),
        .idx(bsz_idx), .wr_data(bus_wdata[BSZ_W-1:0]), .rd_data(bsz_rd)
    );

    // Per-channel event vectors placed onto the status word bit order
    always_comb begin
        txeob_ev_w = '0;
        txde_ev_w  = '0;
        rxeob_ev_w = '0;
        rxde_ev_w  = '0;
        for (int n = 0; n < TX_CH; n++) begin
            txeob_ev_w[31-n] = ev_txeob[n];
            txde_ev_w[31-n]  = ev_txde[n];
        end
        for (int n = 0; n < RX_CH; n++) begin
            rxeob_ev_w[31-n] = ev_rxeob[n];
            rxde_ev_w[31-n]  = ev_rxde[n];
        end
    end

    always_comb begin
        core_d   = core_q;
        soft_rst = 1'b0;
        if (bus_wr) begin
            case (sel)
                SEL_CFG: begin
                    if (bus_wdata[SRST_BIT]) begin
                        core_d   = CORE_INIT;
                        soft_rst = 1'b1;
                    end
                    core_d.cfg = bus_wdata & CFG_KEEP;
                end
                SEL_ESR:   core_d.esr   = core_q.esr & ~bus_wdata;
                SEL_IEN:   core_d.ien   = bus_wdata & IEN_MASK;
                SEL_TXSET: core_d.txact = core_q.txact | (bus_wdata & TX_MASK);
                SEL_TXCLR: core_d.txact = core_q.txact & ~(bus_wdata & TX_MASK);
                SEL_RXSET: core_d.rxact = core_q.rxact | (bus_wdata & RX_MASK);
                SEL_RXCLR: core_d.rxact = core_q.rxact & ~(bus_wdata & RX_MASK);
                SEL_TXEOB: core_d.txeob = core_q.txeob & ~bus_wdata;
                SEL_TXDE:  core_d.txde  = core_q.txde  & ~bus_wdata;
                SEL_RXEOB: core_d.rxeob = core_q.rxeob & ~bus_wdata;
                SEL_RXDE:  core_d.rxde  = core_q.rxde  & ~bus_wdata;
                default: ;
            endcase
        end
        // New events win over a same-cycle clear; a soft reset drops them.
        if (!soft_rst) begin
            core_d.esr   = core_d.esr   | ev_err;
            core_d.txeob = core_d.txeob | txeob_ev_w;
            core_d.txde  = core_d.txde  | txde_ev_w;
            core_d.rxeob = core_d.rxeob | rxeob_ev_w;
            core_d.rxde  = core_d.rxde  | rxde_ev_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= CORE_INIT;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        case (sel)
            SEL_CFG:              bus_rdata = core_q.cfg;
            SEL_ESR:              bus_rdata = core_q.esr;
            SEL_IEN:              bus_rdata = core_q.ien;
            SEL_TXSET, SEL_TXCLR: bus_rdata = core_q.txact;
            SEL_RXSET, SEL_RXCLR: bus_rdata = core_q.rxact;
            SEL_TXEOB:            bus_rdata = core_q.txeob;
            SEL_TXDE:             bus_rdata = core_q.txde;
            SEL_RXEOB:            bus_rdata = core_q.rxeob;
            SEL_RXDE:             bus_rdata = core_q.rxde;
            default: begin
                if (txp_hit) begin
                    bus_rdata = txp_rd;
                end else if (rxp_hit) begin
                    bus_rdata = rxp_rd;
                end else if (bsz_hit) begin
                    bus_rdata = {{(32-BSZ_W){1'b0}}, bsz_rd};
                end else begin
                    bus_rdata = '0;
                end
            end
        endcase
    end

    dmac_irq_gen u_irq (
        .esr       (core_q.esr),
        .txeob     (core_q.txeob),
        .rxeob     (core_q.rxeob),
        .txde      (core_q.txde),
        .rxde      (core_q.rxde),
        .ien       (core_q.ien[IEN_W-1:0]),
        .irq_err   (irq_err),
        .irq_txeob (irq_txeob),
        .irq_rxeob (irq_rxeob),
        .irq_txde  (irq_txde),
        .irq_rxde  (irq_rxde)
    );

endmodule

// File: rtl/dmac_ctl_regfile_chk.sv
module dmac_ctl_regfile_chk
    import dmac_reg_pkg::*;
#(
    parameter int TX_CH = 4,
    parameter int AW    = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic [31:0]   ev_err,
    input logic [31:0]   cfg,
    input logic [31:0]   esr,
    input logic [31:0]   ien,
    input logic [31:0]   txact,
    input logic          irq_err,
    input logic          irq_txeob,
    input logic [31:0]   txeob
);

    localparam logic [31:0] TXM = ~(32'hFFFF_FFFF >> TX_CH);

    p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_CFG)) |=> (cfg == ($past(bus_wdata) & CFG_KEEP)));

    p_soft_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_CFG) && bus_wdata[SRST_BIT])
        |=> (esr == 32'h0 && ien == 32'h0 && txact == 32'h0 && txeob == 32'h0));

    p_esr_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_ESR))
        |=> (esr == (($past(esr) & ~$past(bus_wdata)) | $past(ev_err))));

    p_ien_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_IEN)) |=> (ien == ($past(bus_wdata) & 32'h1F)));

    p_txset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADR_TXSET))
        |=> ((txact & ($past(bus_wdata) & TXM)) == ($past(bus_wdata) & TXM)));

    p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'('h183)) |-> (bus_rdata == 32'h0));

    p_irq_err_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien[IE_ERR] || esr == 32'h0) |-> !irq_err);

    p_irq_err_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[IE_ERR] && esr != 32'h0) |-> irq_err);

    p_irq_txeob_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[IE_TXEOB] && txeob != 32'h0) |-> irq_txeob);

endmodule

bind dmac_ctl_regfile dmac_ctl_regfile_chk #(.TX_CH(TX_CH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_err    (ev_err),
    .cfg       (core_q.cfg),
    .esr       (core_q.esr),
    .ien       (core_q.ien),
    .txact     (core_q.txact),
    .irq_err   (irq_err),
    .irq_txeob (irq_txeob),
    .txeob     (core_q.txeob)
);

// File: tb/dmac_ctl_regfile_test.sv
module dmac_ctl_regfile_test;

    localparam int TX_CH = 4;
    localparam int RX_CH = 2;
    localparam int AW    = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [31:0]      ev_err = '0;
    logic [TX_CH-1:0] ev_txeob = '0;
    logic [TX_CH-1:0] ev_txde = '0;
    logic [RX_CH-1:0] ev_rxeob = '0;
    logic [RX_CH-1:0] ev_rxde = '0;
    logic             irq_err, irq_txeob, irq_rxeob, irq_txde, irq_rxde;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dmac_ctl_regfile #(.TX_CH(TX_CH), .RX_CH(RX_CH), .AW(AW), .BSZ_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_err(ev_err),
        .ev_txeob(ev_txeob), .ev_txde(ev_txde), .ev_rxeob(ev_rxeob),
        .ev_rxde(ev_rxde), .irq_err(irq_err), .irq_txeob(irq_txeob),
        .irq_rxeob(irq_rxeob), .irq_txde(irq_txde), .irq_rxde(irq_rxde)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
        bus_addr = AW'(a);
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic irq_check(input string tag, input logic [4:0] exp);
        #1;
        check(tag, {27'h0, irq_rxde, irq_txde, irq_rxeob, irq_txeob, irq_err}, {27'h0, exp});
    endtask

    task automatic t_reset();
        rd_check("R1 cfg", 'h180, 32'h0007C000);
        rd_check("R1 esr", 'h181, 32'h0);
        rd_check("R1 ien", 'h182, 32'h0);
        rd_check("R1 txact", 'h184, 32'h0);
        rd_check("R1 rxeob", 'h192, 32'h0);
        rd_check("R1 txptr0", 'h1A0, 32'h0);
        rd_check("R1 bsz1", 'h1E1, 32'h0);
        irq_check("R1 irqs", 5'b00000);
    endtask

    task automatic t_cfg();
        wr('h180, 32'h7FFFFFFF);
        rd_check("R2 cfg ones", 'h180, 32'h00FFC087);
        wr('h180, 32'h12345678);
        rd_check("R2 cfg mix", 'h180, 32'h00344000);
    endtask

    task automatic t_ien();
        wr('h182, 32'hFFFFFFFF);
        rd_check("R6 ien ones", 'h182, 32'h0000001F);
        wr('h182, 32'h0);
    endtask

    task automatic t_active();
        wr('h184, 32'hFFFFFFFF);
        rd_check("R7 txset read", 'h184, 32'hF0000000);
        rd_check("R7 txclr read", 'h185, 32'hF0000000);
        wr('h185, 32'h50000000);
        rd_check("R7 tx partial clear", 'h184, 32'hA0000000);
        wr('h190, 32'h7FFFFFFF);
        rd_check("R7 rx field", 'h190, 32'h40000000);
        wr('h190, 32'h80000000);
        rd_check("R7 rx set more", 'h191, 32'hC0000000);
        wr('h191, 32'h40000000);
        rd_check("R7 rx clear", 'h190, 32'h80000000);
    endtask

    task automatic t_events();
        @(negedge clk);
        ev_txeob = 4'b0101;
        ev_rxde  = 2'b10;
        ev_err   = 32'h00000311;
        @(negedge clk);
        ev_txeob = '0;
        ev_rxde  = '0;
        ev_err   = '0;
        rd_check("R5 txeob map", 'h186, 32'hA0000000);
        rd_check("R5 rxde map", 'h193, 32'h40000000);
        rd_check("R5 esr", 'h181, 32'h00000311);
        wr('h186, 32'h80000000);
        rd_check("R4 txeob w1c", 'h186, 32'h20000000);
        wr('h181, 32'h00000001);
        rd_check("R4 esr w1c", 'h181, 32'h00000310);
        // clear of bit 4 collides with a new event on bit 4
        @(negedge clk);
        bus_addr  = AW'('h181);
        bus_wdata = 32'h00000010;
        bus_wr    = 1'b1;
        ev_err    = 32'h00000010;
        @(negedge clk);
        bus_wr    = 1'b0;
        ev_err    = '0;
        rd_check("R4 event beats clear", 'h181, 32'h00000310);
        @(negedge clk);
        ev_txde = 4'b0010;
        @(negedge clk);
        ev_txde = '0;
        rd_check("R5 txde map", 'h187, 32'h40000000);
    endtask

    task automatic t_irq();
        irq_check("R10 all disabled", 5'b00000);
        wr('h182, 32'h01);
        irq_check("R10 err only", 5'b00001);
        wr('h182, 32'h02);
        irq_check("R10 txeob only", 5'b00010);
        wr('h186, 32'hFFFFFFFF);
        irq_check("R10 txeob cleared", 5'b00000);
        wr('h182, 32'h1C);
        irq_check("R10 de classes", 5'b11000);
        wr('h193, 32'hFFFFFFFF);
        irq_check("R10 rxde cleared", 5'b01000);
    endtask

    task automatic t_ptrs();
        for (int n = 0; n < TX_CH; n++) wr('h1A0 + n, 32'hA5000000 + n);
        wr('h1C0, 32'hDEADBEEF);
        wr('h1C1, 32'h0BADF00D);
        wr('h1E0, 32'h1234ABCD);
        wr('h1E1, 32'h00000177);
        for (int n = 0; n < TX_CH; n++) rd_check("R8 txptr", 'h1A0 + n, 32'hA5000000 + n);
        rd_check("R8 rxptr0", 'h1C0, 32'hDEADBEEF);
        rd_check("R8 rxptr1", 'h1C1, 32'h0BADF00D);
        rd_check("R8 bsz0 low byte", 'h1E0, 32'h000000CD);
        rd_check("R8 bsz1 low byte", 'h1E1, 32'h00000077);
    endtask

    task automatic t_unmapped();
        wr('h1A4, 32'h0000DEAD);
        rd_check("R9 tx slot past count", 'h1A4, 32'h0);
        rd_check("R9 last tx slot kept", 'h1A3, 32'hA5000003);
        wr('h1C2, 32'h11111111);
        rd_check("R9 rx slot past count", 'h1C2, 32'h0);
        rd_check("R9 rx slot0 kept", 'h1C0, 32'hDEADBEEF);
        rd_check("R9 bsz past count", 'h1E2, 32'h0);
        wr('h183, 32'hFFFFFFFF);
        rd_check("R9 gap addr", 'h183, 32'h0);
        rd_check("R9 cfg untouched", 'h180, 32'h00344000);
        rd_check("R9 ien untouched", 'h182, 32'h0000001C);
    endtask

    task automatic t_soft();
        wr('h184, 32'h30000000);
        @(negedge clk);
        ev_rxeob = 2'b01;
        @(negedge clk);
        ev_rxeob = '0;
        rd_check("R3 pre rxeob", 'h192, 32'h80000000);
        wr('h180, 32'h80000001);
        rd_check("R3 cfg after", 'h180, 32'h00000001);
        rd_check("R3 esr", 'h181, 32'h0);
        rd_check("R3 ien", 'h182, 32'h0);
        rd_check("R3 txact", 'h184, 32'h0);
        rd_check("R3 rxact", 'h190, 32'h0);
        rd_check("R3 rxeob", 'h192, 32'h0);
        rd_check("R3 txde", 'h187, 32'h0);
        rd_check("R3 txptr kept", 'h1A1, 32'hA5000001);
        rd_check("R3 bsz kept", 'h1E0, 32'h000000CD);
        irq_check("R3 irqs low", 5'b00000);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_ien();
        t_active();
        t_events();
        t_irq();
        t_ptrs();
        t_unmapped();
        t_soft();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule